// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for a short burst in a cache-style synchronous memory. On a clock edge where a start is accepted, it captures the whole input address. The low two bits of that address become the start offset of a four-beat burst. Each later beat is produced inside the block, and the block moves one beat forward only on edges where the advance input is high. A static mode pin selects the order of the beats. Linear order counts upward and wraps inside the aligned group of four. Interleaved order combines the start offset with the beat number by exclusive-OR.

A burst can be opened by two start sources. The processor-side strobe needs only the gating chip select (active low) to be low. The controller-side strobe needs all three chip selects active. When both start and advance are present on the same edge, the start wins. The output is the captured upper address followed by the current beat's low bits. It is driven only from registers and the static mode pin.

Top module: `burst_seq_top`

## Requirements
- R1: While reset is asserted, and after it is released, `addrOut` is zero until the first accepted start.
- R2: `procStrobe` high with `csN` low loads `addrIn` at the clock edge, and `addrOut` equals it after that edge. The two other chip selects do not affect this path.
- R3: `ctrlStrobe` high loads `addrIn` only when `csN` is low, `cs2` is high and `cs3N` is low. Otherwise it has no effect.
- R4: `procStrobe` is ignored while `csN` is high. The output then holds, or steps if `advance` is high, exactly as if `procStrobe` were low.
- R5: Between starts, bits `[ADDR_W-1:2]` of `addrOut` never change.
- R6: With no accepted start and `advance` low, `addrOut` holds its value.
- R7: With `modeInterleave` low (linear), beat n has low bits equal to (start + n) mod 4.
- R8: With `modeInterleave` high (interleaved), beat n has low bits equal to start XOR n.
- R9: Advancing from the fourth beat returns the low bits to the start offset in both orders.
- R10: An accepted start on the same edge as `advance` reloads from `addrIn`, and no step is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Address captured on an accepted start |
| procStrobe | input | 1 | Processor-side start strobe, active high, gated by `csN` |
| ctrlStrobe | input | 1 | Controller-side start strobe, active high, gated by all chip selects |
| advance | input | 1 | Step to the next beat, active high |
| csN | input | 1 | Gating chip select, active low |
| cs2 | input | 1 | Second chip select, active high |
| cs3N | input | 1 | Third chip select, active low |
| modeInterleave | input | 1 | Static order select: 0 linear, 1 interleaved |
| addrOut | output | ADDR_W | Captured upper address with the burst-sequenced low bits |

## Verification
The bench builds the block with its defaults: `ADDR_W` = 8 and `BEAT_W` = 2. This small address width lets the bench sweep every start offset in both orders, with several distinct upper-address patterns. It also walks each burst through all four beats and back to the start offset. Because the sequence field is only two bits, every beat transition and every gating combination of the two strobes and three chip selects can be reached in a short run. The bench also covers the reload-over-advance case in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } burstCtl_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic      procStrobe,
  input  logic      ctrlStrobe,
  input  logic      advance,
  input  logic      csN,
  input  logic      cs2,
  input  logic      cs3N,
  output burstCtl_t ctl
);
  logic chipOn;
  logic procGo;
  logic ctrlGo;

  always_comb begin
    chipOn   = ~csN & cs2 & ~cs3N;
    procGo   = procStrobe & ~csN;     // gated by csN only (R2, R4)
    ctrlGo   = ctrlStrobe & chipOn;   // needs full selection (R3)
    ctl.load = procGo | ctrlGo;
    ctl.step = advance & ~ctl.load;   // start has priority (R10)
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtl_t         ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] upperQ;
  logic [BEAT_W-1:0]  startQ;
  logic [BEAT_W-1:0]  beatQ;
  logic [BEAT_W-1:0]  seqLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
    end else if (ctl.load) begin
      upperQ <= addrIn[ADDR_W-1:BEAT_W];
      startQ <= addrIn[BEAT_W-1:0];
      beatQ  <= '0;
    end else if (ctl.step) begin
      beatQ  <= beatQ + 1'b1;         // natural wrap after the last beat
    end
  end

  always_comb begin
    if (modeInterleave) seqLow = startQ ^ beatQ;
    else                seqLow = startQ + beatQ;
    addrOut = {upperQ, seqLow};
  end
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              advance,
  input  logic              csN,
  input  logic              cs2,
  input  logic              cs3N,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] addrOut
);
  burstCtl_t ctl;

  burst_seq_ctrl u_ctrl (
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .advance    (advance),
    .csN        (csN),
    .cs2        (cs2),
    .cs3N       (cs3N),
    .ctl        (ctl)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .addrIn         (addrIn),
    .modeInterleave (modeInterleave),
    .addrOut        (addrOut)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              procStrobe,
  input logic              ctrlStrobe,
  input logic              advance,
  input logic              csN,
  input logic              cs2,
  input logic              cs3N,
  input logic              modeInterleave,
  input logic [ADDR_W-1:0] addrOut
);
  logic anyStart;
  assign anyStart = (procStrobe && !csN) || (ctrlStrobe && !csN && cs2 && !cs3N);

  // R1
  always_comb begin
    if (!rstN) p_reset_zero_r1: assert (addrOut == '0);
  end

  // R2
  p_proc_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe && !csN) |=> addrOut == $past(addrIn));

  // R3
  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobe && !csN && cs2 && !cs3N) |=> addrOut == $past(addrIn));

  // R4
  p_proc_blocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe && csN && !advance) |=> (!$stable(modeInterleave) || $stable(addrOut)));

  // R5
  p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    !anyStart |=> addrOut[ADDR_W-1:BEAT_W] == $past(addrOut[ADDR_W-1:BEAT_W]));

  // R6
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStart && !advance) |=> (!$stable(modeInterleave) || $stable(addrOut)));

  // R7, R9: a linear step is +1 modulo the group, including the wrap
  p_linear_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStart && advance && !modeInterleave) |=>
      (modeInterleave || (addrOut[BEAT_W-1:0] == BEAT_W'($past(addrOut[BEAT_W-1:0]) + 1))));
endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobe(procStrobe),
  .ctrlStrobe(ctrlStrobe), .advance(advance), .csN(csN), .cs2(cs2),
  .cs3N(cs3N), .modeInterleave(modeInterleave), .addrOut(addrOut)
);

// File: tb/sim_burst_seq_top.sv
module sim_burst_seq_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addrIn = '0;
  logic       procStrobe = 1'b0, ctrlStrobe = 1'b0, advance = 1'b0;
  logic       csN = 1'b1, cs2 = 1'b0, cs3N = 1'b1;
  logic       modeInterleave = 1'b0;
  logic [7:0] addrOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_seq_top u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobe(procStrobe),
    .ctrlStrobe(ctrlStrobe), .advance(advance), .csN(csN), .cs2(cs2),
    .cs3N(cs3N), .modeInterleave(modeInterleave), .addrOut(addrOut)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    procStrobe = 0; ctrlStrobe = 0; advance = 0;
    csN = 1; cs2 = 0; cs3N = 1;
  endtask

  function automatic logic [1:0] expLow(input logic m, input logic [1:0] s, input int n);
    if (m) return s ^ 2'(n);
    return 2'((int'(s) + n) % 4);
  endfunction

  task automatic procLoad(input logic [7:0] a);
    addrIn = a; procStrobe = 1; csN = 0;
    tick();
    idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ups [4];
    logic [7:0] held;
    ups[0] = 8'h00; ups[1] = 8'hA4; ups[2] = 8'h5C; ups[3] = 8'hFC;
    idle();
    addrIn = 8'hFF;
    tick(); tick();
    chk("R1 in reset", addrOut, 8'h00);
    rstN = 1;
    tick();
    chk("R1 after reset", addrOut, 8'h00);

    // R7 R8 R9 R5: sweep mode x start x upper through all beats and wrap
    for (int m = 0; m < 2; m++) begin
      modeInterleave = 1'(m);
      for (int u = 0; u < 4; u++) begin
        for (int s = 0; s < 4; s++) begin
          logic [7:0] base;
          base = ups[u] | 8'(s);
          procLoad(base);
          chk("R2 beat0", addrOut, base);
          for (int n = 1; n <= 4; n++) begin
            advance = 1;
            tick();
            advance = 0;
            chk(m ? "R8 interleaved beat" : "R7 linear beat", addrOut,
                {base[7:2], expLow(1'(m), 2'(s), n % 4)});
            if (n == 4) chk("R9 wrap to start", addrOut, base);
            tick();
            chk("R6 hold", addrOut, {base[7:2], expLow(1'(m), 2'(s), n % 4)});
          end
        end
      end
    end

    // R2: proc path loads with only csN low, other selects inactive
    modeInterleave = 0;
    addrIn = 8'h37; procStrobe = 1; csN = 0; cs2 = 0; cs3N = 1;
    tick(); idle();
    chk("R2 proc load other cs idle", addrOut, 8'h37);

    // R4: proc ignored while csN high, holding
    held = addrOut;
    addrIn = 8'hC8; procStrobe = 1; csN = 1; cs2 = 1; cs3N = 0;
    tick(); idle();
    chk("R4 proc blocked hold", addrOut, held);
    // R4: proc ignored while csN high, advance still steps
    addrIn = 8'hC8; procStrobe = 1; csN = 1; advance = 1;
    tick(); idle();
    chk("R4 proc blocked step", addrOut, 8'h34);

    // R3: ctrl strobe gating
    addrIn = 8'h91; ctrlStrobe = 1; csN = 0; cs2 = 0; cs3N = 0;
    tick(); idle();
    chk("R3 ctrl blocked cs2", addrOut, 8'h34);
    addrIn = 8'h91; ctrlStrobe = 1; csN = 0; cs2 = 1; cs3N = 1;
    tick(); idle();
    chk("R3 ctrl blocked cs3N", addrOut, 8'h34);
    addrIn = 8'h91; ctrlStrobe = 1; csN = 1; cs2 = 1; cs3N = 0;
    tick(); idle();
    chk("R3 ctrl blocked csN", addrOut, 8'h34);
    addrIn = 8'h91; ctrlStrobe = 1; csN = 0; cs2 = 1; cs3N = 0;
    tick(); idle();
    chk("R3 ctrl load", addrOut, 8'h91);

    // R10: reload mid-burst takes priority over advance
    procLoad(8'h25);
    advance = 1; tick(); tick(); advance = 0;
    chk("R7 mid-burst beat2", addrOut, 8'h27);
    addrIn = 8'h9E; procStrobe = 1; csN = 0; advance = 1;
    tick(); idle();
    chk("R10 reload over advance", addrOut, 8'h9E);
    advance = 1; tick(); advance = 0;
    chk("R10 new burst beat1", addrOut, 8'h9F);
    modeInterleave = 1;
    addrIn = 8'h4B; ctrlStrobe = 1; csN = 0; cs2 = 1; cs3N = 0; advance = 1;
    tick(); idle();
    chk("R10 ctrl reload over advance", addrOut, 8'h4B);
    advance = 1; tick(); advance = 0;
    chk("R8 beat1 after reload", addrOut, 8'h4A);
    chk("R5 upper kept", {2'b00, addrOut[7:2]}, {2'b00, 6'h12});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule